// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and drives two processor outputs: a fast interrupt line and a normal interrupt line. Each source's raw level is the OR of its input pin, captured by a register, and a bit that software can set. Software routes each source either to the fast line or to the normal line. The normal line can also be gated by a per-source enable. The enable has no effect on the fast line.

The normal line is prioritised through 16 programmable vector slots. Each slot names one source and holds a handler address. There is also one default, unvectored level. The controller keeps the current service level, where 17 means idle. Reading the vector register acknowledges an interrupt: it moves to a more urgent pending level and records the level it left. Writing the vector register ends service and returns to the recorded level. Nested preemption follows from this saved chain. Each level gates the normal line through a preemption mask, which is rebuilt from the slot controls.

Every bus access is decoded into one of five access kinds: `ACC_NONE`, `ACC_READ`, `ACC_WRITE`, `ACC_ACK` (a read of the vector register) and `ACC_EOI` (a write of the vector register).

The service level has two transitions:
- raise, on `ACC_ACK` when a more urgent level is pending;
- return, on `ACC_EOI` when the level is not idle.

Top module: `vec_intc_top`

## Requirements
- R1: Word 2 (byte 0x008) reads the raw vector, which is the captured pins OR the soft bits. Word 0 reads raw & enable & ~fastsel. Word 1 reads raw & fastsel. A pin change appears in raw one clock edge after it is applied.
- R2: `fiq_o` is high exactly when raw & fastsel is non-zero, whatever the enable register holds.
- R3: Writing a one to a bit of word 4 (0x010) sets that enable bit, and writing a one to word 5 (0x014) clears it; word 4 reads the enables. Words 6 and 7 (0x018, 0x01C) set and clear the soft bits in the same way, and word 6 reads them.
- R4: In a slot control byte, bit 5 enables the slot and bits 4:0 name its source. The mask of level i (0..15) is the set of sources named by the enabled slots below i. Level 16 takes the sources of all enabled slots, and level 17 takes all sources.
- R5: `irq_o` = OR of (raw & enable & ~fastsel & mask of the current level).
- R6: A read of word 12 (0x030) picks the lowest level i below the current one for which raw & mask(i) is non-zero. If such a level exists, its predecessor becomes the current level and i becomes current. The read returns the address of the resulting level: the slot address for levels 0..15 and the default address for levels 16 and 17.
- R7: A write of any value to word 12 returns a non-idle level to its saved predecessor. At idle, the write has no effect.
- R8: The following registers read back what was written:
  - fastsel at word 3 (0x00C);
  - protection, bit 0 only, at word 8 (0x020);
  - default address at word 13 (0x034);
  - slot n address at 0x100+4n;
  - slot n control, low 8 bits, at 0x200+4n.
- R9: Bytes 0xFE0 to 0xFFC read the identification bytes 0x21, 0x37, 0x4C, 0x00, 0x9A, 0x5E, 0x13 and 0xB7, in that order.
- R10: The following accesses change no state and, for reads, return zero:
  - writes to word 0;
  - writes to unmapped words;
  - reads of unmapped words;
  - an access that asserts both read and write.
- R11: After reset, every register, slot address, slot control and the default address is zero. The level is idle (17) and both outputs are low.
- R12: Read data is registered: it is valid after the clock edge that takes the read, and it holds until the next read. Write effects show on the outputs right after the edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A pin change takes one edge to reach the raw vector and both outputs. A register write, an acknowledge or an end-of-service shows on `irq_o` and `fiq_o` right after the edge that takes it. Read data appears after the edge that takes the read and holds after that. The bench drives every input on the falling edge and advances its behavioural model on the rising edge. It compares `irq_o`, `fiq_o` and `bus_rdata_o` on every falling edge, so each result is checked in the first cycle it is due. A directed check also confirms that a pin change is not yet visible before that edge.

// File: rtl/vec_intc_pkg.sv
`timescale 1ns/1ps
package vec_intc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORD_W = ADDR_W - 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_ACK,
        ACC_EOI
    } acc_kind_e;

    localparam logic [WORD_W-1:0] WD_IRQ_STAT = 10'h000;
    localparam logic [WORD_W-1:0] WD_FIQ_STAT = 10'h001;
    localparam logic [WORD_W-1:0] WD_RAW      = 10'h002;
    localparam logic [WORD_W-1:0] WD_FSEL     = 10'h003;
    localparam logic [WORD_W-1:0] WD_EN_SET   = 10'h004;
    localparam logic [WORD_W-1:0] WD_EN_CLR   = 10'h005;
    localparam logic [WORD_W-1:0] WD_SW_SET   = 10'h006;
    localparam logic [WORD_W-1:0] WD_SW_CLR   = 10'h007;
    localparam logic [WORD_W-1:0] WD_PROT     = 10'h008;
    localparam logic [WORD_W-1:0] WD_VECT     = 10'h00C;
    localparam logic [WORD_W-1:0] WD_DEFV     = 10'h00D;
    localparam logic [WORD_W-1:0] WD_SLOT_A   = 10'h040;
    localparam logic [WORD_W-1:0] WD_SLOT_C   = 10'h080;
    localparam logic [WORD_W-1:0] WD_ID       = 10'h3F8;

    // identification bytes, one per word of the top eight words
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] b;
        unique case (k)
            3'd0: b = 8'h21;
            3'd1: b = 8'h37;
            3'd2: b = 8'h4C;
            3'd3: b = 8'h00;
            3'd4: b = 8'h9A;
            3'd5: b = 8'h5E;
            3'd6: b = 8'h13;
            3'd7: b = 8'hB7;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vec_intc_mask_gen.sv
`timescale 1ns/1ps
module vec_intc_mask_gen #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    localparam int NLVL  = NSLOT + 2,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic [NSLOT-1:0][7:0]     slot_ctl,
    output logic [NLVL-1:0][NSRC-1:0] lvl_mask
);

    logic [NSRC-1:0] slot_bit [NSLOT];
    logic [NSLOT-1:0][1:0] unused_hi;

    // one decoded source bit per slot, zero when the slot is off
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_bit[s]  = slot_ctl[s][5]
                            ? (NSRC'(1) << slot_ctl[s][SEL_W-1:0])
                            : '0;
        assign unused_hi[s] = slot_ctl[s][7:6];
    end

    // running OR: level i sees every enabled slot below it
    always_comb begin
        logic [NSRC-1:0] run;
        run = '0;
        for (int l = 0; l < NSLOT; l++) begin
            lvl_mask[l] = run;
            run = run | slot_bit[l];
        end
        lvl_mask[NSLOT]  = run;
        lvl_mask[NLVL-1] = '1;
    end

endmodule

// File: rtl/vec_intc_svc_track.sv
`timescale 1ns/1ps
module vec_intc_svc_track #(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16,
    localparam int NLVL  = NSLOT + 2,
    localparam int LVL_W = $clog2(NLVL),
    localparam int IDLE  = NLVL - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           raw,
    input  logic [NLVL-1:0][NSRC-1:0] lvl_mask,
    input  logic                      ack_i,
    input  logic                      eoi_i,
    output logic [LVL_W-1:0]          cur_lvl_o,
    output logic [LVL_W-1:0]          hit_lvl_o
);

    logic [LVL_W-1:0]           cur_q;
    logic [NLVL-1:0][LVL_W-1:0] prev_q;
    logic [LVL_W-1:0]           hit;

    // most urgent pending level strictly above the current one
    always_comb begin
        hit = cur_q;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if ((LVL_W'(i) < cur_q) && (|(raw & lvl_mask[i]))) begin
                hit = LVL_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LVL_W'(IDLE);
            for (int l = 0; l < NLVL; l++) begin
                prev_q[l] <= LVL_W'(IDLE);
            end
        end else if (ack_i && (hit < cur_q)) begin
            prev_q[hit] <= cur_q;
            cur_q       <= hit;
        end else if (eoi_i && (cur_q != LVL_W'(IDLE))) begin
            cur_q <= prev_q[cur_q];
        end
    end

    assign cur_lvl_o = cur_q;
    assign hit_lvl_o = hit;

    // R6
    ack_no_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (cur_q <= $past(cur_q)));

    // R7
    eoi_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (cur_q != LVL_W'(IDLE))) |=> (cur_q > $past(cur_q)));

    // R7
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (cur_q == LVL_W'(IDLE))) |=> (cur_q == LVL_W'(IDLE)));

    // R5
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= LVL_W'(IDLE));

endmodule

// File: rtl/vec_intc_top.sv
`timescale 1ns/1ps
module vec_intc_top
    import vec_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NSLOT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int NLVL   = NSLOT + 2;
    localparam int LVL_W  = $clog2(NLVL);
    localparam int SLOT_W = $clog2(NSLOT);

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_lsb;
    acc_kind_e         acc;

    logic [NSRC-1:0]              src_q, soft_q, en_q, fsel_q, raw;
    logic                         prot_q;
    logic [DATA_W-1:0]            defv_q, rdata_q, rd_val;
    logic [NSLOT-1:0][DATA_W-1:0] vaddr_q;
    logic [NSLOT-1:0][7:0]        vctl_q;
    logic [NLVL-1:0][NSRC-1:0]    lvl_mask;
    logic [LVL_W-1:0]             cur_lvl, hit_lvl;
    logic                         slot_a, slot_c;
    logic [SLOT_W-1:0]            sidx_a, sidx_c;
    logic [NSRC-1:0]              wd_src;

    assign word       = bus_addr_i[ADDR_W-1:2];
    assign unused_lsb = bus_addr_i[1:0];
    assign wd_src     = bus_wdata_i[NSRC-1:0];
    assign raw        = src_q | soft_q;

    assign slot_a = (word >= WD_SLOT_A) && (word < WD_SLOT_A + WORD_W'(NSLOT));
    assign slot_c = (word >= WD_SLOT_C) && (word < WD_SLOT_C + WORD_W'(NSLOT));
    assign sidx_a = SLOT_W'(word - WD_SLOT_A);
    assign sidx_c = SLOT_W'(word - WD_SLOT_C);

    // access decode: both strobes together count as no access
    always_comb begin
        unique case ({bus_wr_i, bus_rd_i})
            2'b10:   acc = (word == WD_VECT) ? ACC_EOI : ACC_WRITE;
            2'b01:   acc = (word == WD_VECT) ? ACC_ACK : ACC_READ;
            default: acc = ACC_NONE;
        endcase
    end

    vec_intc_mask_gen #(.NSRC(NSRC), .NSLOT(NSLOT)) u_mask (
        .slot_ctl (vctl_q),
        .lvl_mask (lvl_mask)
    );

    vec_intc_svc_track #(.NSRC(NSRC), .NSLOT(NSLOT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (raw),
        .lvl_mask  (lvl_mask),
        .ack_i     (acc == ACC_ACK),
        .eoi_i     (acc == ACC_EOI),
        .cur_lvl_o (cur_lvl),
        .hit_lvl_o (hit_lvl)
    );

    // read value selection
    always_comb begin
        rd_val = '0;
        if (word >= WD_ID) begin
            rd_val = DATA_W'(id_byte(word[2:0]));
        end else if (slot_a) begin
            rd_val = vaddr_q[sidx_a];
        end else if (slot_c) begin
            rd_val = DATA_W'(vctl_q[sidx_c]);
        end else begin
            case (word)
                WD_IRQ_STAT: rd_val = DATA_W'(raw & en_q & ~fsel_q);
                WD_FIQ_STAT: rd_val = DATA_W'(raw & fsel_q);
                WD_RAW:      rd_val = DATA_W'(raw);
                WD_FSEL:     rd_val = DATA_W'(fsel_q);
                WD_EN_SET:   rd_val = DATA_W'(en_q);
                WD_SW_SET:   rd_val = DATA_W'(soft_q);
                WD_PROT:     rd_val = DATA_W'(prot_q);
                WD_DEFV:     rd_val = defv_q;
                default:     rd_val = '0;
            endcase
        end
        if (acc == ACC_ACK) begin
            rd_val = (hit_lvl >= LVL_W'(NSLOT)) ? defv_q
                                                : vaddr_q[hit_lvl[SLOT_W-1:0]];
        end
    end

    // register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            soft_q  <= '0;
            en_q    <= '0;
            fsel_q  <= '0;
            prot_q  <= 1'b0;
            defv_q  <= '0;
            vaddr_q <= '0;
            vctl_q  <= '0;
            rdata_q <= '0;
        end else begin
            src_q <= irq_src_i;
            unique case (acc)
                ACC_WRITE: begin
                    case (word)
                        WD_FSEL:   fsel_q <= wd_src;
                        WD_EN_SET: en_q   <= en_q | wd_src;
                        WD_EN_CLR: en_q   <= en_q & ~wd_src;
                        WD_SW_SET: soft_q <= soft_q | wd_src;
                        WD_SW_CLR: soft_q <= soft_q & ~wd_src;
                        WD_PROT:   prot_q <= bus_wdata_i[0];
                        WD_DEFV:   defv_q <= bus_wdata_i;
                        default: begin
                            if (slot_a) vaddr_q[sidx_a] <= bus_wdata_i;
                            if (slot_c) vctl_q[sidx_c]  <= bus_wdata_i[7:0];
                        end
                    endcase
                end
                ACC_READ, ACC_ACK: rdata_q <= rd_val;
                ACC_NONE, ACC_EOI: ;
            endcase
        end
    end

    // output drive
    assign bus_rdata_o = rdata_q;
    assign irq_o = |(raw & en_q & ~fsel_q & lvl_mask[cur_lvl]);
    assign fiq_o = |(raw & fsel_q);

    // R5
    irq_lvl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_lvl != '0));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((acc == ACC_READ) || (acc == ACC_ACK)) |=> $stable(bus_rdata_o));

    // R10
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc == ACC_WRITE) && (word == WD_IRQ_STAT))
        |=> ($stable(en_q) && $stable(fsel_q) && $stable(soft_q)));

endmodule

// File: tb/vec_intc_top_tb.sv
`timescale 1ns/1ps
module vec_intc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    always #2.5 clk = ~clk;

    vec_intc_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src_i(src),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    int    checks = 0;
    int    fails  = 0;
    string note   = "reset";
    bit    done   = 0;

    // behavioural model
    logic [31:0] m_src, m_soft, m_en, m_fsel, m_defv, m_rd, m_raw;
    logic        m_prot;
    logic [31:0] m_va [16];
    logic [7:0]  m_vc [16];
    int          m_cur, m_hit, m_w;
    int          m_prev [17];
    string       m_rtag = "R11";
    bit          m_live = 0;

    function automatic logic [31:0] mmask(int l);
        logic [31:0] m;
        if (l == 17) return '1;
        m = '0;
        for (int s = 0; s < l && s < 16; s++)
            if (m_vc[s][5]) m[m_vc[s][4:0]] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] mid(int k);
        logic [7:0] t [8] = '{8'h21, 8'h37, 8'h4C, 8'h00, 8'h9A, 8'h5E, 8'h13, 8'hB7};
        return t[k];
    endfunction

    function automatic logic [31:0] mread(int w, logic [31:0] r);
        if (w >= 1016) return {24'b0, mid(w - 1016)};
        if (w >= 64 && w < 80) return m_va[w-64];
        if (w >= 128 && w < 144) return {24'b0, m_vc[w-128]};
        case (w)
            0: return r & m_en & ~m_fsel;
            1: return r & m_fsel;
            2: return r;
            3: return m_fsel;
            4: return m_en;
            6: return m_soft;
            8: return {31'b0, m_prot};
            13: return m_defv;
            default: return '0;
        endcase
    endfunction

    function automatic string rtag(int w);
        if (w == 12) return "R6";
        if (w <= 2) return "R1";
        if (w == 4 || w == 6) return "R3";
        if (w >= 1016) return "R9";
        if (w == 3 || w == 8 || w == 13 || (w >= 64 && w < 80) || (w >= 128 && w < 144))
            return "R8";
        return "R10";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = '0; m_soft = '0; m_en = '0; m_fsel = '0; m_defv = '0;
            m_prot = 1'b0; m_rd = '0; m_cur = 17; m_rtag = "R11";
            for (int s = 0; s < 16; s++) begin m_va[s] = '0; m_vc[s] = '0; end
            for (int l = 0; l < 17; l++) m_prev[l] = 17;
            m_live = 1;
        end else begin
            m_raw = m_src | m_soft;
            m_w   = int'(bus_addr[11:2]);
            if (bus_rd && !bus_wr) begin
                if (m_w == 12) begin
                    m_hit = m_cur;
                    for (int i = 0; i < m_cur; i++)
                        if ((m_raw & mmask(i)) != 0) begin m_hit = i; break; end
                    if (m_hit < m_cur) begin m_prev[m_hit] = m_cur; m_cur = m_hit; end
                    m_rd = (m_hit >= 16) ? m_defv : m_va[m_hit];
                end else begin
                    m_rd = mread(m_w, m_raw);
                end
                m_rtag = rtag(m_w);
            end
            if (bus_wr && !bus_rd) begin
                case (m_w)
                    3:  m_fsel = bus_wdata;
                    4:  m_en   = m_en | bus_wdata;
                    5:  m_en   = m_en & ~bus_wdata;
                    6:  m_soft = m_soft | bus_wdata;
                    7:  m_soft = m_soft & ~bus_wdata;
                    8:  m_prot = bus_wdata[0];
                    12: if (m_cur != 17) m_cur = m_prev[m_cur];
                    13: m_defv = bus_wdata;
                    default: begin
                        if (m_w >= 64 && m_w < 80) m_va[m_w-64] = bus_wdata;
                        else if (m_w >= 128 && m_w < 144) m_vc[m_w-128] = bus_wdata[7:0];
                    end
                endcase
            end
            m_src = src;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): act=%h exp=%h", req, note, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk("R5", {31'b0, irq},
                {31'b0, |((m_src | m_soft) & m_en & ~m_fsel & mmask(m_cur))});
            chk("R2", {31'b0, fiq}, {31'b0, |((m_src | m_soft) & m_fsel)});
            chk(m_rtag, rdata, m_rd);
        end
    end

    task automatic wr_reg(int a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 12'(a);
        @(negedge clk); bus_rd = 1'b0;
        chk(req, rdata, exp);
    endtask

    task automatic set_src(logic [31:0] v);
        @(negedge clk); src = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        note = "reset state";
        chk("R11", {31'b0, irq}, 32'd0);
        chk("R11", {31'b0, fiq}, 32'd0);
        chk("R11", rdata, 32'd0);
        rd_chk("R11", 'h010, 0);
        rd_chk("R11", 'h034, 0);
        rd_chk("R11", 'h104, 0);
        rd_chk("R11", 'h204, 0);
        rd_chk("R6", 'h030, 0);

        note = "id bytes";
        rd_chk("R9", 'hFE0, 32'h21); rd_chk("R9", 'hFE4, 32'h37);
        rd_chk("R9", 'hFE8, 32'h4C); rd_chk("R9", 'hFEC, 32'h00);
        rd_chk("R9", 'hFF0, 32'h9A); rd_chk("R9", 'hFF4, 32'h5E);
        rd_chk("R9", 'hFF8, 32'h13); rd_chk("R9", 'hFFC, 32'hB7);

        note = "ignored accesses";
        rd_chk("R10", 'h040, 0);
        wr_reg('h000, 32'hFFFF_FFFF);
        rd_chk("R10", 'h010, 0);
        wr_reg('h0A0, 32'hFFFF_FFFF);
        @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'hFF;
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        rd_chk("R10", 'h00C, 0);

        note = "enable and soft ports";
        wr_reg('h010, 32'h0000_F00F); rd_chk("R3", 'h010, 32'h0000_F00F);
        wr_reg('h014, 32'h0000_0003); rd_chk("R3", 'h010, 32'h0000_F00C);
        wr_reg('h018, 32'h0000_0104); rd_chk("R3", 'h018, 32'h0000_0104);
        wr_reg('h01C, 32'h0000_0004); rd_chk("R3", 'h018, 32'h0000_0100);

        note = "status views";
        rd_chk("R1", 'h008, 32'h0000_0100);
        set_src(32'h0000_8001);
        rd_chk("R1", 'h008, 32'h0000_8101);
        rd_chk("R1", 'h000, 32'h0000_8000);
        chk("R5", {31'b0, irq}, 1);

        note = "fast routing";
        wr_reg('h00C, 32'h0000_8100);
        rd_chk("R1", 'h004, 32'h0000_8100);
        rd_chk("R1", 'h000, 0);
        chk("R2", {31'b0, fiq}, 1);
        chk("R5", {31'b0, irq}, 0);
        wr_reg('h014, 32'hFFFF_FFFF);
        chk("R2", {31'b0, fiq}, 1);
        rd_chk("R8", 'h00C, 32'h0000_8100);
        wr_reg('h00C, 0);
        wr_reg('h01C, 32'hFFFF_FFFF);
        set_src(0);

        note = "slot programming";
        wr_reg('h020, 32'h3);         rd_chk("R8", 'h020, 1);
        wr_reg('h034, 32'h0000_DEF0); rd_chk("R8", 'h034, 32'h0000_DEF0);
        wr_reg('h100, 32'h0000_A000);
        wr_reg('h104, 32'h0000_A100);
        wr_reg('h108, 32'h0000_A200);
        wr_reg('h200, 32'h25);
        wr_reg('h204, 32'h29);
        wr_reg('h208, 32'h0C);
        rd_chk("R8", 'h204, 32'h29);
        rd_chk("R8", 'h104, 32'h0000_A100);
        wr_reg('h010, 32'h0000_1220);

        note = "nesting";
        set_src(32'h0000_0200);
        chk("R5", {31'b0, irq}, 1);
        rd_chk("R6", 'h030, 32'h0000_A200);
        chk("R5", {31'b0, irq}, 1);
        set_src(32'h0000_0220);
        rd_chk("R6", 'h030, 32'h0000_A100);
        chk("R5", {31'b0, irq}, 1);
        set_src(32'h0000_0200);
        chk("R4", {31'b0, irq}, 0);
        set_src(32'h0000_1000);
        chk("R4", {31'b0, irq}, 0);
        rd_chk("R6", 'h030, 32'h0000_A100);
        note = "end of service";
        wr_reg('h030, 0);
        chk("R7", {31'b0, irq}, 0);
        set_src(32'h0000_0020);
        chk("R7", {31'b0, irq}, 1);
        wr_reg('h030, 0);
        set_src(32'h0000_1000);
        chk("R7", {31'b0, irq}, 1);
        wr_reg('h030, 0);
        chk("R7", {31'b0, irq}, 1);
        rd_chk("R6", 'h030, 32'h0000_DEF0);

        note = "timing";
        @(negedge clk); src = 0;
        chk("R12", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R12", {31'b0, irq}, 0);

        note = "random";
        for (int n = 0; n < 4000; n++) begin
            int sel, w;
            @(negedge clk);
            sel = int'($urandom_range(0, 14));
            case (sel)
                9:  w = 12;
                10: w = 13;
                11: w = 64 + int'($urandom_range(0, 15));
                12: w = 128 + int'($urandom_range(0, 15));
                13: w = 1016 + int'($urandom_range(0, 7));
                14: w = 20;
                default: w = sel;
            endcase
            bus_addr = 12'(w * 4);
            bus_wdata = (w >= 128 && w < 144) ? ($urandom() | 32'h20) : $urandom();
            case ($urandom_range(0, 3))
                0: begin bus_rd = 1'b1; bus_wr = 1'b0; end
                1: begin bus_rd = 1'b0; bus_wr = 1'b1; end
                default: begin bus_rd = 1'b0; bus_wr = 1'b0; end
            endcase
            if ($urandom_range(0, 7) == 0) src = $urandom() & $urandom() & $urandom();
        end
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule